// File: doc/BRIEF.md
# Circular and Bit-Reversed Address Generator

This block produces the addresses for one post-modify load. For each request it gives the effective address the access should use, and the value to be written back into the pointer register. The pointer can be updated in several ways: by a signed immediate, by the value of a modifier register, linearly while the address bits are presented in bit-reversed order (for FFT-style buffers), or inside a circular window set by a start register and a length. In circular mode the step is either the immediate in bytes or an increment count packed into the modifier register and scaled by the access size. An absolute mode loads the pointer directly from the immediate.

A request is presented for one cycle with `req_vld` high. The result appears on the next clock edge, with `rsp_vld` high for that one cycle. The memory access is handled by the surrounding load unit.

Top module: `agu_addr_gen`

## Requirements
- R1: `rsp_vld` goes high on the clock edge that samples a request and is low in every other cycle. Reset drives `rsp_vld`, `rsp_ea` and `rsp_ptr` to 0.
- R2: In mode 0 (immediate post-increment), `rsp_ea` is the old pointer and `rsp_ptr` is pointer + immediate, modulo 2^32.
- R3: In mode 1 (modifier post-increment), `rsp_ea` is the old pointer and `rsp_ptr` is pointer + modifier, modulo 2^32.
- R4: In mode 2 (bit-reversed), `rsp_ea` keeps pointer bits 31:16 and places pointer bit i (i < 16) at bit 15-i. `rsp_ptr` is pointer + modifier. Starting from a 64K-aligned base with a modifier of 0x2000, four chained accesses produce byte offsets 0, 4, 2, 6.
- R5: In mode 3 (circular, immediate step), the length is modifier bits 16:0 and `rsp_ea` is the old pointer. When the pointer lies inside [start, start+length) and |imm| < length, `rsp_ptr` = start + ((pointer - start + imm) mod length), with the mod result non-negative. With length 6 and step 2, chained pointers relative to start are 2, 4, 0, 2.
- R6: In mode 4 (circular, register step), the increment count is modifier bits 23:17 and the length is bits 16:0. The byte step is count << size, where size code 0..3 means 1, 2, 4 or 8 bytes. The wrap is the same as in R5.
- R7: In modes 3 and 4, a length of zero leaves `rsp_ptr` equal to the old pointer, and `rsp_ea` is the old pointer.
- R8: In mode 5 (absolute set), both `rsp_ea` and `rsp_ptr` equal the immediate.
- R9: Mode codes 6 and 7 return the old pointer on both `rsp_ea` and `rsp_ptr`.
- R10: In a cycle without a request, `rsp_ea` and `rsp_ptr` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request strobe |
| req_mode | input | 3 | Addressing mode code |
| req_size | input | 2 | Access size code (log2 bytes) |
| req_ptr | input | 32 | Current pointer register value |
| req_mod | input | 32 | Modifier register value |
| req_start | input | 32 | Circular window start |
| req_imm | input | 32 | Immediate (signed step or absolute address) |
| rsp_vld | output | 1 | Result strobe, one cycle after the request |
| rsp_ea | output | 32 | Effective address for this access |
| rsp_ptr | output | 32 | Pointer value to write back |

## Verification
In bit-reversed mode, the reversal of the address and the linear pointer add happen in the same access. When the pointer's low half is close to 0xFFFF, the add carries into the upper half while the effective address still keeps the old upper half. A sweep starting just below a 64K boundary provokes this case. The bench then checks that `rsp_ea` has the pre-carry upper bits and `rsp_ptr` has the incremented ones. A second overlap arises in the circular sweeps: the effective address uses the pointer before the step, while the written-back pointer may wrap high or low in the same cycle. The bench checks both outputs of that single response against values it computes with integer modulo arithmetic.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    AGU_PI_IMM   = 3'd0,
    AGU_PI_REG   = 3'd1,
    AGU_BREV     = 3'd2,
    AGU_CIRC_IMM = 3'd3,
    AGU_CIRC_REG = 3'd4,
    AGU_ABS      = 3'd5
  } agu_mode_e;
endpackage

// File: rtl/agu_ea_gen.sv
module agu_ea_gen
  import agu_pkg::*;
#(
  parameter int AW       = 32,
  parameter int REV_BITS = 16
) (
  input  logic [2:0]    mode,
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] imm,
  output logic [AW-1:0] ea,
  output logic          brev_sel
);
  // Mirror the low field: bit i moves to bit REV_BITS-1-i.
  function automatic logic [REV_BITS-1:0] mirror(input logic [REV_BITS-1:0] v);
    logic [REV_BITS-1:0] r;
    for (int i = 0; i < REV_BITS; i++) r[i] = v[REV_BITS-1-i];
    return r;
  endfunction

  assign brev_sel = (mode == AGU_BREV);

  always_comb begin
    case (agu_mode_e'(mode))
      AGU_BREV: ea = {ptr[AW-1:REV_BITS], mirror(ptr[REV_BITS-1:0])};
      AGU_ABS:  ea = imm;
      default:  ea = ptr;
    endcase
  end
endmodule

// File: rtl/agu_circ_wrap.sv
module agu_circ_wrap #(
  parameter int AW       = 32,
  parameter int LEN_BITS = 17,
  parameter int CNT_BITS = 7,
  parameter int SIZE_W   = 2
) (
  input  logic                         use_reg,
  input  logic [SIZE_W-1:0]            size,
  input  logic [AW-1:0]                ptr,
  input  logic [AW-1:0]                start,
  input  logic [LEN_BITS+1:0]          imm_lo,
  input  logic [LEN_BITS+CNT_BITS-1:0] mod_fld,
  output logic [AW-1:0]                nxt_ptr,
  output logic                         wrap_hi,
  output logic                         wrap_lo,
  output logic                         len_zero
);
  localparam int SW = LEN_BITS + 2;

  // Byte step from packed count and access size.
  function automatic logic [SW-1:0] scale_step(input logic [CNT_BITS-1:0] cnt,
                                               input logic [SIZE_W-1:0] sz);
    return SW'(cnt) << sz;
  endfunction

  // Single conditional correction back into [0, len).
  function automatic logic [LEN_BITS-1:0] fold(input logic signed [SW-1:0] s,
                                               input logic signed [SW-1:0] l);
    logic signed [SW-1:0] t;
    if (s < 0)       t = s + l;
    else if (s >= l) t = s - l;
    else             t = s;
    return t[LEN_BITS-1:0];
  endfunction

  logic [LEN_BITS-1:0]  len;
  logic [CNT_BITS-1:0]  cnt;
  logic [LEN_BITS-1:0]  off;
  logic signed [SW-1:0] step_s;
  logic signed [SW-1:0] len_s;
  logic signed [SW-1:0] sum_s;
  logic [LEN_BITS-1:0]  new_off;

  assign len     = mod_fld[LEN_BITS-1:0];
  assign cnt     = mod_fld[LEN_BITS +: CNT_BITS];
  assign off     = ptr[LEN_BITS-1:0] - start[LEN_BITS-1:0];
  assign step_s  = use_reg ? $signed(scale_step(cnt, size)) : $signed(imm_lo);
  assign len_s   = $signed({2'b00, len});
  assign sum_s   = $signed({2'b00, off}) + step_s;
  assign wrap_lo = (sum_s < 0);
  assign wrap_hi = (sum_s >= len_s);
  assign len_zero = (len == '0);
  assign new_off = fold(sum_s, len_s);
  assign nxt_ptr = len_zero ? ptr : start + {{(AW-LEN_BITS){1'b0}}, new_off};
endmodule

// File: rtl/agu_addr_gen.sv
module agu_addr_gen
  import agu_pkg::*;
#(
  parameter int AW       = 32,
  parameter int REV_BITS = 16,
  parameter int LEN_BITS = 17,
  parameter int CNT_BITS = 7,
  parameter int SIZE_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [2:0]        req_mode,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [AW-1:0]     req_ptr,
  input  logic [AW-1:0]     req_mod,
  input  logic [AW-1:0]     req_start,
  input  logic [AW-1:0]     req_imm,
  output logic              rsp_vld,
  output logic [AW-1:0]     rsp_ea,
  output logic [AW-1:0]     rsp_ptr
);
  localparam int MOD_W  = LEN_BITS + CNT_BITS;
  localparam int STEP_W = LEN_BITS + 2;

  logic [AW-1:0] ea_c;
  logic [AW-1:0] circ_nxt;
  logic [AW-1:0] nxt_c;
  logic          brev_sel;
  logic          wrap_hi;
  logic          wrap_lo;
  logic          len_zero;
  logic          circ_sel;

  agu_ea_gen #(.AW(AW), .REV_BITS(REV_BITS)) u_ea (
    .mode     (req_mode),
    .ptr      (req_ptr),
    .imm      (req_imm),
    .ea       (ea_c),
    .brev_sel (brev_sel)
  );

  agu_circ_wrap #(.AW(AW), .LEN_BITS(LEN_BITS), .CNT_BITS(CNT_BITS), .SIZE_W(SIZE_W)) u_circ (
    .use_reg  (req_mode == AGU_CIRC_REG),
    .size     (req_size),
    .ptr      (req_ptr),
    .start    (req_start),
    .imm_lo   (req_imm[STEP_W-1:0]),
    .mod_fld  (req_mod[MOD_W-1:0]),
    .nxt_ptr  (circ_nxt),
    .wrap_hi  (wrap_hi),
    .wrap_lo  (wrap_lo),
    .len_zero (len_zero)
  );

  assign circ_sel = (req_mode == AGU_CIRC_IMM) || (req_mode == AGU_CIRC_REG);

  always_comb begin
    if (circ_sel) nxt_c = circ_nxt;
    else if (brev_sel) nxt_c = req_ptr + req_mod;
    else begin
      case (agu_mode_e'(req_mode))
        AGU_PI_IMM: nxt_c = req_ptr + req_imm;
        AGU_PI_REG: nxt_c = req_ptr + req_mod;
        AGU_ABS:    nxt_c = req_imm;
        default:    nxt_c = req_ptr;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld <= 1'b0;
      rsp_ea  <= '0;
      rsp_ptr <= '0;
    end else begin
      rsp_vld <= req_vld;
      if (req_vld) begin
        rsp_ea  <= ea_c;
        rsp_ptr <= nxt_c;
      end
    end
  end
endmodule

// File: rtl/agu_addr_gen_chk.sv
module agu_addr_gen_chk
  import agu_pkg::*;
#(
  parameter int AW       = 32,
  parameter int REV_BITS = 16,
  parameter int LEN_BITS = 17
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_vld,
  input logic [2:0]          req_mode,
  input logic [AW-1:0]       req_ptr,
  input logic [AW-1:0]       req_start,
  input logic [AW-1:0]       req_imm,
  input logic [LEN_BITS-1:0] req_len,
  input logic                rsp_vld,
  input logic [AW-1:0]       rsp_ea,
  input logic [AW-1:0]       rsp_ptr,
  input logic                wrap_hi,
  input logic                wrap_lo,
  input logic                len_zero
);
  logic circ_m;
  logic inwin;
  assign circ_m = (req_mode == AGU_CIRC_IMM) || (req_mode == AGU_CIRC_REG);
  assign inwin  = (req_ptr - req_start) < {{(AW-LEN_BITS){1'b0}}, req_len};

  AST_VLD_RISE: assert property (@(posedge clk) disable iff (!rst_n) req_vld |=> rsp_vld); // R1
  AST_VLD_DROP: assert property (@(posedge clk) disable iff (!rst_n) !req_vld |=> !rsp_vld); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> ($stable(rsp_ea) && $stable(rsp_ptr))); // R10
  AST_EA_PRE_MODIFY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && (req_mode == AGU_PI_IMM || req_mode == AGU_PI_REG || circ_m))
    |=> rsp_ea == $past(req_ptr)); // R2
  AST_BREV_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_mode == AGU_BREV)
    |=> rsp_ea[AW-1:REV_BITS] == $past(req_ptr[AW-1:REV_BITS])); // R4
  AST_ABS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_mode == AGU_ABS)
    |=> (rsp_ea == rsp_ptr) && (rsp_ptr == $past(req_imm))); // R8
  AST_CIRC_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && circ_m && !len_zero && inwin)
    |=> (rsp_ptr - $past(req_start)) < {{(AW-LEN_BITS){1'b0}}, $past(req_len)}); // R5
  AST_ONE_WRAP_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wrap_hi, wrap_lo})); // R5
  AST_LEN_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && circ_m && len_zero) |=> rsp_ptr == $past(req_ptr)); // R7
  AST_RSVD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_mode[2:1] == 2'b11)
    |=> (rsp_ptr == $past(req_ptr)) && (rsp_ea == $past(req_ptr))); // R9
endmodule

bind agu_addr_gen agu_addr_gen_chk #(.AW(AW), .REV_BITS(REV_BITS), .LEN_BITS(LEN_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_vld   (req_vld),
  .req_mode  (req_mode),
  .req_ptr   (req_ptr),
  .req_start (req_start),
  .req_imm   (req_imm),
  .req_len   (req_mod[LEN_BITS-1:0]),
  .rsp_vld   (rsp_vld),
  .rsp_ea    (rsp_ea),
  .rsp_ptr   (rsp_ptr),
  .wrap_hi   (wrap_hi),
  .wrap_lo   (wrap_lo),
  .len_zero  (len_zero)
);

// File: tb/agu_addr_gen_tb.sv
module agu_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0;
  logic [2:0]  req_mode = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_ptr = '0, req_mod = '0, req_start = '0, req_imm = '0;
  logic        rsp_vld;
  logic [31:0] rsp_ea, rsp_ptr;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  agu_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_mode(req_mode),
    .req_size(req_size), .req_ptr(req_ptr), .req_mod(req_mod),
    .req_start(req_start), .req_imm(req_imm), .rsp_vld(rsp_vld),
    .rsp_ea(rsp_ea), .rsp_ptr(rsp_ptr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // One request, result sampled at the following falling edge.
  task automatic issue(input logic [2:0] m, input logic [1:0] sz, input logic [31:0] p,
                       input logic [31:0] md, input logic [31:0] st, input logic [31:0] im);
    @(negedge clk);
    req_mode = m; req_size = sz; req_ptr = p; req_mod = md; req_start = st; req_imm = im;
    req_vld = 1'b1;
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  function automatic logic [15:0] flip16(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[15-i] = v[i];
    return r;
  endfunction

  function automatic logic [31:0] circ_ref(input logic [31:0] p, input logic [31:0] st,
                                           input int len, input int step);
    int off, o;
    off = int'(p - st);
    o = ((off + step) % len + len) % len;
    return st + 32'(o);
  endfunction

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] p, ea_hold, ptr_hold;
    repeat (3) @(negedge clk);
    chk("R1 reset vld", {31'b0, rsp_vld}, 32'd0);
    chk("R1 reset ea", rsp_ea, 32'd0);
    chk("R1 reset ptr", rsp_ptr, 32'd0);
    rst_n = 1'b1;

    // R1 and R10: strobe timing, then hold while idle
    issue(3'd0, 2'd0, 32'h100, 32'h0, 32'h0, 32'h4);
    chk("R1 vld high", {31'b0, rsp_vld}, 32'd1);
    ea_hold = rsp_ea; ptr_hold = rsp_ptr;
    req_ptr = 32'hDEAD_0000; req_imm = 32'h55; req_mode = 3'd5;
    @(negedge clk);
    chk("R1 vld low", {31'b0, rsp_vld}, 32'd0);
    @(negedge clk);
    chk("R10 ea hold", rsp_ea, ea_hold);
    chk("R10 ptr hold", rsp_ptr, ptr_hold);

    // R2 immediate post-increment, including wrap past 2^32 and negative steps
    for (int i = 0; i < 16; i++) begin
      logic [31:0] pp, im;
      pp = 32'hFFFF_FFF0 + 32'(i * 3);
      im = (i % 2 == 0) ? 32'(i * 7) : -32'(i * 5);
      issue(3'd0, 2'd0, pp, 32'h0, 32'h0, im);
      chk("R2 ea", rsp_ea, pp);
      chk("R2 ptr", rsp_ptr, pp + im);
    end

    // R3 modifier post-increment
    for (int i = 0; i < 16; i++) begin
      logic [31:0] pp, md;
      pp = 32'h0000_8000 * 32'(i) + 32'h13;
      md = 32'h0123_4567 * 32'(i + 1);
      issue(3'd1, 2'd1, pp, md, 32'h0, 32'h0);
      chk("R3 ea", rsp_ea, pp);
      chk("R3 ptr", rsp_ptr, pp + md);
    end

    // R4 chained bit-reversed walk from a 64K-aligned base: offsets 0,4,2,6
    p = 32'h0001_0000;
    for (int k = 0; k < 4; k++) begin
      int exp_off[4] = '{0, 4, 2, 6};
      issue(3'd2, 2'd2, p, 32'h0000_2000, 32'h0, 32'h0);
      chk("R4 brev offset", rsp_ea, 32'h0001_0000 + 32'(exp_off[k]));
      chk("R4 linear ptr", rsp_ptr, p + 32'h2000);
      p = rsp_ptr;
    end
    // R4 sweep across a 64K boundary: carry reaches the pointer, not the address
    for (int i = 0; i < 24; i++) begin
      logic [31:0] pp, md;
      pp = 32'h0003_FFF0 + 32'(i);
      md = 32'(i * 5);
      issue(3'd2, 2'd0, pp, md, 32'h0, 32'h0);
      chk("R4 brev ea", rsp_ea, {pp[31:16], flip16(pp[15:0])});
      chk("R4 brev ptr", rsp_ptr, pp + md);
    end

    // R5 chained circular, length 6 step 2: relative 2,4,0,2
    p = 32'h0000_1000;
    for (int k = 0; k < 4; k++) begin
      int rel[4] = '{2, 4, 0, 2};
      issue(3'd3, 2'd0, p, 32'd6, 32'h0000_1000, 32'd2);
      chk("R5 circ ea", rsp_ea, p);
      chk("R5 circ chain", rsp_ptr, 32'h0000_1000 + 32'(rel[k]));
      p = rsp_ptr;
    end
    // R5 sweep: lengths 1..9, every offset, every step in (-len, len)
    for (int len = 1; len <= 9; len++)
      for (int off = 0; off < len; off++)
        for (int st = -(len - 1); st < len; st++) begin
          logic [31:0] base;
          base = 32'h0002_FFF8 + 32'(len * 3);
          issue(3'd3, 2'd3, base + 32'(off), 32'(len), base, 32'(st));
          chk("R5 circ sweep", rsp_ptr, circ_ref(base + 32'(off), base, len, st));
        end

    // R6 chained register step: count 1, 4-byte access, length 8 -> 4,0,4,0
    p = 32'h0000_2000;
    for (int k = 0; k < 4; k++) begin
      issue(3'd4, 2'd2, p, (32'd1 << 17) | 32'd8, 32'h0000_2000, 32'h0);
      chk("R6 circ ea", rsp_ea, p);
      chk("R6 circ chain", rsp_ptr, 32'h0000_2000 + ((k % 2 == 0) ? 32'd4 : 32'd0));
      p = rsp_ptr;
    end
    // R6 sweep over count and size code with length 64
    for (int c = 0; c < 8; c++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 64; off += 9) begin
          logic [31:0] base, md;
          base = 32'h0004_0000;
          md = (32'(c) << 17) | 32'd64 | 32'hFF00_0000;
          issue(3'd4, 2'(sz), base + 32'(off), md, base, 32'h7);
          chk("R6 circ reg sweep", rsp_ptr, circ_ref(base + 32'(off), base, 64, c << sz));
        end

    // R7 zero length leaves the pointer alone in both circular modes
    issue(3'd3, 2'd0, 32'h0000_3005, 32'h0000_0000, 32'h0000_3000, 32'd3);
    chk("R7 len0 imm ptr", rsp_ptr, 32'h0000_3005);
    chk("R7 len0 imm ea", rsp_ea, 32'h0000_3005);
    issue(3'd4, 2'd1, 32'h0000_3007, 32'h0006_0000, 32'h0000_3000, 32'd0);
    chk("R7 len0 reg ptr", rsp_ptr, 32'h0000_3007);

    // R8 absolute set
    for (int i = 0; i < 4; i++) begin
      logic [31:0] im;
      im = 32'hA5A5_0000 ^ 32'(i * 32'h1111);
      issue(3'd5, 2'd0, 32'h1234, 32'h77, 32'h0, im);
      chk("R8 abs ea", rsp_ea, im);
      chk("R8 abs ptr", rsp_ptr, im);
    end

    // R9 unused mode codes
    for (int m = 6; m < 8; m++) begin
      issue(3'(m), 2'd0, 32'h0BAD_F00D, 32'h10, 32'h0, 32'h20);
      chk("R9 rsvd ea", rsp_ea, 32'h0BAD_F00D);
      chk("R9 rsvd ptr", rsp_ptr, 32'h0BAD_F00D);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule